// File: doc/BRIEF.md
# Eight-Pin GPIO Register Bank

This block is a small general-purpose I/O controller. A host reaches it over a plain synchronous register bus: one write strobe, a word address, 16-bit write data, and combinational read data. Three writable registers hold, for each of the eight pins, a direction bit, a drive-mode bit and an output level. A fourth register is read-only and reports the level seen on each pad.

For every pin the block drives an output-enable, an output value and a pull-up enable to an external tristate pad. An output pin is either push-pull, which drives both levels, or open-drain, which only pulls low and otherwise lets go. A pin that is not driven is held high by the pull-up. The pad level comes back through a two-flop synchronizer and is then readable on every pin, whether it is an input or an output.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction, drive-mode and output-level registers all read 0x0000. Every pin is then an input: `pad_oe` is 0x00 and `pad_pu` is 0xFF.
- R2: Address 0x0 holds the direction register. Bit n set to 1 makes pin n an output, and 0 makes it an input. A write takes effect on the rising edge where `bus_wr` is sampled high.
- R3: Address 0x1 holds the drive mode, where bit n = 1 selects push-pull. A push-pull output pin has `pad_oe`=1 and `pad_out` equal to its level bit.
- R4: A drive-mode bit of 0 selects open-drain. An open-drain output pin has `pad_oe`=1 and `pad_out`=0 when its level bit is 0. When its level bit is 1 it has `pad_oe`=0. An open-drain pin never drives a 1.
- R5: An input pin has `pad_oe`=0 and `pad_out`=0, whatever its drive-mode and level bits are.
- R6: `pad_pu` is 0 only on push-pull output pins. It is 1 on input pins and on open-drain pins.
- R7: Address 0x2 holds the output-level register. It can be read and written.
- R8: Address 0x3 reads the synchronized pad levels. A change on `pad_in` becomes visible after exactly two rising edges. This holds for both input and output pins. Writes to 0x3 are ignored.
- R9: Bits 15:8 of every register read as zero. Writes to those bits are ignored.
- R10: Addresses 0x4 and above read as zero. Writes to them change no register.
- R11: Read data is combinational. It is valid in the same cycle the address is presented, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| pad_in | input | 8 | Resolved pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The drive logic is tried with six configurations of direction, mode and level:
- all pins inputs, with mode and level bits set;
- all pins push-pull;
- all pins open-drain;
- three configurations that mix inputs, push-pull pins and open-drain pins, each with a different level pattern.

These tell apart errors that swap the sense of the mode bit, errors that let mode or level leak into input pins, and errors in the open-drain release. For each configuration the pad level is also read back, which checks that a released pin is pulled high.

Directed cases cover the following:
- the synchronizer delay, by sampling after one edge and again after two;
- writes to the read-only register;
- writes to the upper byte;
- writes to unmapped addresses.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_DIR  = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_MODE = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_LVL  = 4'h2;
    localparam logic [ADDR_W-1:0] ADR_PADS = 4'h3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] async_in,
    output logic [NPIN-1:0] sync_out
);
    typedef struct packed {
        logic [NPIN-1:0] meta;
        logic [NPIN-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
    end

    // Idle pads are pulled high, so both stages reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{meta: '1, stable: '1};
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stable;

    // Checker: count cycles since reset so the two-edge delay is only checked
    // once two real samples of the input exist.
    logic [1:0]      age_q;
    logic [NPIN-1:0] in_p1_q, in_p2_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
        in_p1_q <= async_in;
        in_p2_q <= in_p1_q;
    end

    p_two_edge_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (sync_out == in_p2_q));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NPIN-1:0]   pads_sync,
    output logic [NPIN-1:0]   dir_q,
    output logic [NPIN-1:0]   mode_q,
    output logic [NPIN-1:0]   lvl_q
);
    localparam int PAD_W = DATA_W - NPIN;

    typedef struct packed {
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] mode;
        logic [NPIN-1:0] lvl;
    } regs_t;

    regs_t r_d, r_q;

    // Only the low byte is stored; the upper byte is discarded here.
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:NPIN];

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (addr)
                ADR_DIR:  r_d.dir  = wdata[NPIN-1:0];
                ADR_MODE: r_d.mode = wdata[NPIN-1:0];
                ADR_LVL:  r_d.lvl  = wdata[NPIN-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADR_DIR:  rdata = {{PAD_W{1'b0}}, r_q.dir};
            ADR_MODE: rdata = {{PAD_W{1'b0}}, r_q.mode};
            ADR_LVL:  rdata = {{PAD_W{1'b0}}, r_q.lvl};
            ADR_PADS: rdata = {{PAD_W{1'b0}}, pads_sync};
            default:  rdata = '0;
        endcase
    end

    assign dir_q  = r_q.dir;
    assign mode_q = r_q.mode;
    assign lvl_q  = r_q.lvl;

    // Checker: becomes true one edge after reset is released.
    logic past_ok_q;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(wr_en && addr == ADR_DIR) |-> dir_q == $past(wdata[NPIN-1:0]));
    p_lvl_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(wr_en && addr == ADR_LVL) |-> lvl_q == $past(wdata[NPIN-1:0]));
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:NPIN] == '0);
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > ADR_PADS) |-> rdata == '0);
    p_unmapped_nochange_r10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(addr > ADR_PADS) |-> $stable(r_q));
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
    parameter int NPIN = 8
) (
    input  logic [NPIN-1:0] dir,
    input  logic [NPIN-1:0] mode,
    input  logic [NPIN-1:0] lvl,
    output logic [NPIN-1:0] oe,
    output logic [NPIN-1:0] dout,
    output logic [NPIN-1:0] pu
);
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic push_pull;
        logic open_drain;
        assign push_pull  = dir[g] & mode[g];
        assign open_drain = dir[g] & ~mode[g];
        always_comb begin
            oe[g]   = push_pull | (open_drain & ~lvl[g]);
            dout[g] = push_pull & lvl[g];
            pu[g]   = ~push_pull;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_pu
);
    logic [NPIN-1:0] pads_sync;
    logic [NPIN-1:0] dir_q, mode_q, lvl_q;

    gpio_sync #(.NPIN(NPIN)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pads_sync)
    );

    gpio_regfile #(.NPIN(NPIN), .DATA_W(DATA_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .pads_sync (pads_sync),
        .dir_q     (dir_q),
        .mode_q    (mode_q),
        .lvl_q     (lvl_q)
    );

    gpio_drive #(.NPIN(NPIN)) i_drive (
        .dir  (dir_q),
        .mode (mode_q),
        .lvl  (lvl_q),
        .oe   (pad_oe),
        .dout (pad_out),
        .pu   (pad_pu)
    );

    p_input_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_q) & (pad_oe | pad_out)) == '0);
    p_od_never_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mode_q) & pad_out) == '0);
    p_pp_follows_lvl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & mode_q & (pad_out ^ lvl_q)) == '0);
    p_pullup_off_only_pp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pad_pu) & ~(dir_q & mode_q)) == '0);
endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pad_in, pad_oe, pad_out, pad_pu;
    logic [7:0]  ext_en = '0;
    logic [7:0]  ext_val = '0;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    // Pad model: the block's drive wins, then an external driver, then the pull-up.
    always_comb begin
        for (int i = 0; i < 8; i++) begin
            if (pad_oe[i])      pad_in[i] = pad_out[i];
            else if (ext_en[i]) pad_in[i] = ext_val[i];
            else                pad_in[i] = pad_pu[i];
        end
    end

    gpio_bank i_gpio_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_pu    (pad_pu)
    );

    typedef struct packed {
        logic [7:0] dir, mode, lvl, oe, dout, pu, pads;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{dir: 8'h00, mode: 8'hFF, lvl: 8'hFF, oe: 8'h00, dout: 8'h00, pu: 8'hFF, pads: 8'hFF},
        '{dir: 8'hFF, mode: 8'hFF, lvl: 8'hA5, oe: 8'hFF, dout: 8'hA5, pu: 8'h00, pads: 8'hA5},
        '{dir: 8'hFF, mode: 8'h00, lvl: 8'hA5, oe: 8'h5A, dout: 8'h00, pu: 8'hFF, pads: 8'hA5},
        '{dir: 8'hF0, mode: 8'hCC, lvl: 8'hAA, oe: 8'hD0, dout: 8'h80, pu: 8'h3F, pads: 8'hAF},
        '{dir: 8'h0F, mode: 8'h33, lvl: 8'h0F, oe: 8'h03, dout: 8'h03, pu: 8'hFC, pads: 8'hFF},
        '{dir: 8'h3C, mode: 8'h0F, lvl: 8'h00, oe: 8'h3C, dout: 8'h00, pu: 8'hF3, pads: 8'hC3}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Combinational read: no clock edge between the address and the sample (R11).
    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, r); chk("R1 dir", r, 16'h0000);
        rd(4'h1, r); chk("R1 mode", r, 16'h0000);
        rd(4'h2, r); chk("R1 lvl", r, 16'h0000);
        chk("R1 oe", {8'h0, pad_oe}, 16'h0000);
        chk("R1 pu", {8'h0, pad_pu}, 16'h00FF);

        // Vector table: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 6; v++) begin
            wr(4'h0, {8'h00, VECS[v].dir});
            wr(4'h1, {8'h00, VECS[v].mode});
            wr(4'h2, {8'h00, VECS[v].lvl});
            chk("R3 R4 R5 oe", {8'h0, pad_oe}, {8'h0, VECS[v].oe});
            chk("R3 R4 R5 out", {8'h0, pad_out}, {8'h0, VECS[v].dout});
            chk("R6 pu", {8'h0, pad_pu}, {8'h0, VECS[v].pu});
            rd(4'h0, r); chk("R2 dir readback", r, {8'h0, VECS[v].dir});
            rd(4'h1, r); chk("R3 mode readback", r, {8'h0, VECS[v].mode});
            rd(4'h2, r); chk("R7 lvl readback", r, {8'h0, VECS[v].lvl});
            repeat (3) @(negedge clk);
            rd(4'h3, r); chk("R8 pad levels", r, {8'h0, VECS[v].pads});
        end

        // R2: the write lands on the edge where the strobe is sampled
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 16'h0000;
        #1; chk("R2 before edge", {8'h0, pad_oe}, 16'h003C);
        @(posedge clk); @(negedge clk); bus_wr = 1'b0;
        chk("R2 after edge", {8'h0, pad_oe}, 16'h0000);

        // R8: two-edge synchronizer delay on input pins
        wr(4'h2, 16'h00FF);
        repeat (3) @(negedge clk);
        ext_en = 8'hFF; ext_val = 8'h3C;
        @(posedge clk); @(negedge clk);
        rd(4'h3, r); chk("R8 after one edge", r, 16'h00FF);
        @(posedge clk); @(negedge clk);
        rd(4'h3, r); chk("R8 after two edges", r, 16'h003C);

        // R8: a write to the pad register is ignored
        wr(4'h3, 16'h00FF);
        rd(4'h3, r); chk("R8 write ignored", r, 16'h003C);
        rd(4'h2, r); chk("R8 lvl untouched", r, 16'h00FF);

        // R8: an output pin reports the pad level, including an external pull-down
        ext_val = 8'h00;
        wr(4'h0, 16'h0001);
        wr(4'h1, 16'h0000);
        repeat (3) @(negedge clk);
        rd(4'h3, r); chk("R8 open-drain released pin reads pad", r, 16'h0000);
        ext_en = 8'h00;

        // R9: upper byte is ignored on write and reads as zero
        wr(4'h0, 16'hFF00);
        rd(4'h0, r); chk("R9 upper byte dir", r, 16'h0000);
        chk("R9 oe", {8'h0, pad_oe}, 16'h0000);
        wr(4'h2, 16'hA55A);
        rd(4'h2, r); chk("R9 upper byte lvl", r, 16'h005A);

        // R10: unmapped addresses
        wr(4'h5, 16'hFFFF);
        wr(4'hF, 16'hFFFF);
        rd(4'h5, r); chk("R10 read 0x5", r, 16'h0000);
        rd(4'hF, r); chk("R10 read 0xF", r, 16'h0000);
        rd(4'h0, r); chk("R10 dir unchanged", r, 16'h0000);
        rd(4'h1, r); chk("R10 mode unchanged", r, 16'h0000);
        rd(4'h2, r); chk("R10 lvl unchanged", r, 16'h005A);

        // R11: address changes are reflected without a clock edge
        @(negedge clk);
        rd(4'h2, r); chk("R11 same-cycle lvl", r, 16'h005A);
        rd(4'h4, r); chk("R11 same-cycle unmapped", r, 16'h0000);

        // R1: reset again clears the registers
        wr(4'h0, 16'h00FF);
        wr(4'h1, 16'h00FF);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); @(negedge clk) rst_n = 1'b1;
        rd(4'h0, r); chk("R1 dir after re-reset", r, 16'h0000);
        rd(4'h2, r); chk("R1 lvl after re-reset", r, 16'h0000);
        chk("R1 pu after re-reset", {8'h0, pad_pu}, 16'h00FF);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule